// File: doc/BRIEF.md
# Burst Column Address Sequence Generator

This block turns one burst request into the column addresses of that burst, one per clock. A request gives a starting column, a burst length of 1, 2, 4 or 8 words and an ordering. The block then walks the aligned group of words that holds the starting column. It starts at the requested word and wraps inside the group, so the requested word always comes out first.

Two orderings are supported. In sequential order the beat number is added to the low column bits, and any carry out of the burst-length field is lost. In interleaved order the beat number is XORed into those same bits. Every beat carries a valid flag, and the final beat also carries a last flag. A stop input ends a running burst early. A new request made during a burst drops the old burst and starts the new one. Memory array timing, read latency and the data path belong to other blocks.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first request is accepted, `beat_valid_o` and `beat_last_o` are 0.
- R2: A request sampled on a rising edge (`req_i`=1) makes the first beat appear right after that edge. Its address equals the requested column `req_col_i`.
- R3: `req_len_i` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. The beats come out on consecutive cycles with no gaps.
- R4: Every address of a burst lies in the aligned group of N words (N = beat count) that contains the starting column. No address repeats within a burst.
- R5: With `req_order_i`=0 (sequential), beat i has low-field value (start + i) mod N. For example, start 5 with N=4 gives 5,6,7,4, and start 5 with N=8 gives 5,6,7,0,1,2,3,4.
- R6: With `req_order_i`=1 (interleaved), beat i has low-field value start XOR i. For example, start 5 with N=4 gives 5,4,7,6, and start 5 with N=8 gives 5,4,7,6,1,0,3,2.
- R7: For N=1 and N=2, and for any start aligned to its group, both orderings give the same sequence. That sequence is ascending for an aligned start.
- R8: Column bits at index 3 and above keep the starting column's value for the whole burst.
- R9: `beat_last_o` is 1 on the final beat only. On the following cycle `beat_valid_o` is 0 unless a new request was accepted.
- R10: `stop_i`=1, sampled while a beat is shown and without a request, removes all later beats: `beat_valid_o` is 0 on the next cycle. A stop while idle has no effect.
- R11: A request sampled during a burst drops the old burst, and the new burst's first beat appears on the next cycle. A request takes priority over a stop sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start a burst this edge |
| req_col_i | input | COL_W | Starting column |
| req_len_i | input | 2 | Burst length code: 0/1/2/3 for 1/2/4/8 beats |
| req_order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| beat_valid_o | output | 1 | Beat address is valid |
| beat_col_o | output | COL_W | Column address of this beat |
| beat_last_o | output | 1 | Final beat of the burst |

## Verification
Several checks run on every cycle. One confirms that the first beat repeats the requested column one cycle after the request. Others check that the beat counter steps by one with no gap, that the upper column bits stay fixed during a burst, and that the last flag never appears without a valid beat. Further checks confirm that a stop or a final beat leaves the outputs idle on the next cycle. The exact wrapped order of each burst is checked only by the bench scenarios: the directed examples with start 5, the aligned and short-burst equivalence, the mid-burst restart and stop cases, and the random requests. Each of these is compared against the bench's own modulo and XOR arithmetic.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int FIELD_W = 3;

  typedef enum logic [1:0] {LEN_1 = 2'd0, LEN_2 = 2'd1, LEN_4 = 2'd2, LEN_8 = 2'd3} len_e;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR = 1'b1} order_e;

  function automatic logic [FIELD_W-1:0] len_mask(len_e len);
    logic [FIELD_W-1:0] m;
    case (len)
      LEN_1:   m = 3'b000;
      LEN_2:   m = 3'b001;
      LEN_4:   m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

  // Low-field value of beat cnt for a burst whose start has low field low.
  function automatic logic [FIELD_W-1:0] beat_field(logic [FIELD_W-1:0] low,
                                                    logic [FIELD_W-1:0] cnt,
                                                    len_e len, order_e ord);
    logic [FIELD_W-1:0] m;
    logic [FIELD_W-1:0] sum;
    m   = len_mask(len);
    sum = low + cnt;
    if (ord == ORD_XOR) return low ^ (cnt & m);
    return (low & ~m) | (sum & m);
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  len_e               req_len_i,
  input  order_e             req_order_i,
  input  logic               stop_i,
  output logic               active_o,
  output logic [FIELD_W-1:0] cnt_o,
  output logic [COL_W-1:0]   base_o,
  output len_e               len_o,
  output order_e             order_o,
  output logic               last_o
);
  logic accept_w;
  logic finish_w;
  logic step_w;

  assign last_o   = (cnt_o == len_mask(len_o));
  assign accept_w = req_i;
  assign finish_w = active_o && !accept_w && (stop_i || last_o);
  assign step_w   = active_o && !accept_w && !finish_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      base_o   <= '0;
      len_o    <= LEN_1;
      order_o  <= ORD_SEQ;
    end else if (accept_w) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
      base_o   <= req_col_i;
      len_o    <= req_len_i;
      order_o  <= req_order_i;
    end else if (finish_w) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
    end else if (step_w) begin
      cnt_o <= cnt_o + 3'd1;
    end
  end

  // R2: an accepted request shows beat 0 on the next cycle
  p_req_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (active_o && cnt_o == 3'd0));

  // R3: beats advance by one with no gap
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !last_o && !stop_i && !req_i) |=> (active_o && cnt_o == $past(cnt_o) + 3'd1));

  // R9: after the final beat the generator goes idle
  p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && last_o && !req_i) |=> !active_o);

  // R10: stop removes all later beats
  p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && stop_i && !req_i) |=> !active_o);
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]   base_i,
  input  logic [FIELD_W-1:0] cnt_i,
  input  len_e               len_i,
  input  order_e             order_i,
  output logic [COL_W-1:0]   col_o
);
  localparam int UPPER_W = COL_W - FIELD_W;

  logic [FIELD_W-1:0] field_w;

  assign field_w = beat_field(base_i[FIELD_W-1:0], cnt_i, len_i, order_i);

  generate
    if (UPPER_W > 0) begin : g_upper
      assign col_o = {base_i[COL_W-1:FIELD_W], field_w};
    end else begin : g_narrow
      assign col_o = field_w[COL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [1:0]       req_len_i,
  input  logic             req_order_i,
  input  logic             stop_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_last_o
);
  logic               active_w;
  logic [FIELD_W-1:0] cnt_w;
  logic [COL_W-1:0]   base_w;
  len_e               len_w;
  order_e             order_w;
  logic               last_w;

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .req_col_i  (req_col_i),
    .req_len_i  (len_e'(req_len_i)),
    .req_order_i(order_e'(req_order_i)),
    .stop_i     (stop_i),
    .active_o   (active_w),
    .cnt_o      (cnt_w),
    .base_o     (base_w),
    .len_o      (len_w),
    .order_o    (order_w),
    .last_o     (last_w)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_addr (
    .base_i (base_w),
    .cnt_i  (cnt_w),
    .len_i  (len_w),
    .order_i(order_w),
    .col_o  (beat_col_o)
  );

  assign beat_valid_o = active_w;
  assign beat_last_o  = active_w && last_w;

  // R2: first beat repeats the requested column
  p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (beat_valid_o && beat_col_o == $past(req_col_i)));

  // R8: upper column bits hold for the whole burst
  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !req_i && !stop_i && !beat_last_o)
      |=> (beat_col_o[COL_W-1:FIELD_W] == $past(beat_col_o[COL_W-1:FIELD_W])));

  // R9: last flag only on a valid beat
  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);

  // R1: idle outputs straight after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!beat_valid_o && !beat_last_o));
endmodule

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_i = 1'b0;
  logic [COL_W-1:0] req_col_i = '0;
  logic [1:0]       req_len_i = '0;
  logic             req_order_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             beat_valid_o;
  logic [COL_W-1:0] beat_col_o;
  logic             beat_last_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_col_i(req_col_i),
    .req_len_i(req_len_i), .req_order_i(req_order_i), .stop_i(stop_i),
    .beat_valid_o(beat_valid_o), .beat_col_o(beat_col_o), .beat_last_o(beat_last_o)
  );

  // Expected column: group base plus wrapped offset, by modulo or by XOR.
  function automatic int exp_col(int start, int len_code, int ord, int i);
    int n, grp, off;
    n   = 1 << len_code;
    off = start % n;
    grp = start - off;
    if (ord == 0) return grp + ((off + i) % n);
    return grp + (off ^ i);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a request at a falling edge; the first beat is checked at the next one.
  task automatic issue(int col, int len_code, int ord);
    req_i = 1'b1; req_col_i = COL_W'(col); req_len_i = 2'(len_code); req_order_i = ord[0];
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic check_beats(string req, int col, int len_code, int ord, int upto);
    for (int i = 0; i < upto; i++) begin
      chk({req, " valid"}, int'(beat_valid_o), 1);
      chk({req, " col"}, int'(beat_col_o), exp_col(col, len_code, ord, i));
      chk({req, " last"}, int'(beat_last_o), (i == (1 << len_code) - 1) ? 1 : 0);
      if (i != upto - 1) @(negedge clk);
    end
  endtask

  task automatic full_burst(string req, int col, int len_code, int ord);
    issue(col, len_code, ord);
    check_beats(req, col, len_code, ord, 1 << len_code);
    @(negedge clk);
    chk({req, " R9 idle after last"}, int'(beat_valid_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(beat_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(beat_valid_o), 0);
        chk("R1 last after reset", int'(beat_last_o), 0);

        // R5 / R6 directed examples
        full_burst("R5 seq start5 BL4", 5, 2, 0);
        full_burst("R5 seq start5 BL8", 5, 3, 0);
        full_burst("R6 xor start5 BL4", 5, 2, 1);
        full_burst("R6 xor start5 BL8", 5, 3, 1);
        // R3 / R7 short bursts, both orders
        full_burst("R3 R7 BL1 seq", 13, 0, 0);
        full_burst("R3 R7 BL1 xor", 13, 0, 1);
        full_burst("R7 BL2 odd seq", 1021 % 1024, 1, 0);
        full_burst("R7 BL2 odd xor", 1021 % 1024, 1, 1);
        // R7 aligned start ascending in both orders; R8 upper bits kept
        full_burst("R7 R8 aligned seq", 10'h2A8, 3, 0);
        full_burst("R7 R8 aligned xor", 10'h2A8, 3, 1);
        full_burst("R4 R8 top seq", 10'h3FE, 3, 0);

        // R10 stop in mid-burst
        issue(3, 3, 0);
        check_beats("R10 pre-stop", 3, 3, 0, 3);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R10 no beat after stop", int'(beat_valid_o), 0);
        // R10 stop while idle has no effect
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R10 idle stop", int'(beat_valid_o), 0);
        full_burst("R10 burst after idle stop", 6, 2, 1);

        // R11 restart during a burst
        issue(17, 3, 0);
        check_beats("R11 old", 17, 3, 0, 2);
        issue(42, 2, 1);
        check_beats("R11 new", 42, 2, 1, 4);
        @(negedge clk);
        chk("R11 idle after new", int'(beat_valid_o), 0);
        // R11 request wins over stop on the same edge
        issue(100, 3, 1);
        check_beats("R11 old2", 100, 3, 1, 1);
        stop_i = 1'b1;
        issue(201, 1, 0);
        stop_i = 1'b0;
        check_beats("R11 req over stop", 201, 1, 0, 2);
        @(negedge clk);

        // Random requests (R2 R4 R5 R6)
        begin
          int unused;
          unused = $urandom(32'h5eed_1234);
        end
        for (int k = 0; k < 300; k++) begin
          int c, l, o;
          c = int'($urandom % 1024);
          l = int'($urandom % 4);
          o = int'($urandom % 2);
          full_burst("R2 R4 R5 R6 random", c, l, o);
        end
      end
      begin
        repeat (100000) @(negedge clk);
        if (!done) begin
          n_checks++;
          n_fails++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule